// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings an LCD panel's supplies and its display output up and down in a fixed interleaved order, with every gap measured in display frames. On power-up it enables the logic supply first, then lets pixel data and panel timing out, and enables the drive-voltage supply last. On power-down it runs the reverse: drive-voltage supply off, then display output off, then logic supply off. A two-bit status reports whether the panel counts as powered.

A single 16-bit configuration word holds four 4-bit gap fields, each encoding a frame count minus one. Writes reach the running sequence only while the block is idle. A write made while a sequence runs is stored and used from the next power-up onward. Every control and status pin is a plain level or a single-cycle pulse. There is no streaming interface and no back-pressure.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, all three enables are 0, the status is 00, and the configuration word is 0xF60F, so the gaps are A=16, B=7, E=1 and F=16 frames.
- R2: On power-up, `logic_en` rises on the clock edge that samples `pwr_req` high in idle. `disp_en` rises A frames later, and `drive_en` rises B frames after that. Each enable changes on the edge that samples the deciding `frame_tick`.
- R3: The configuration fields are: bits 15:12 for gap A (logic on to display on), bits 11:8 for gap B (display on to drive on), bits 7:4 for gap E (drive off to display off), and bits 3:0 for gap F (display off to logic off). A field value N gives a gap of N+1 frame ticks.
- R4: On power-down from full power, `drive_en` falls on the edge that samples `pwr_req` low. `disp_en` falls E frames later, and `logic_en` falls F frames after that.
- R5: `drive_en` is never high unless `disp_en` is high. `disp_en` is never high unless `logic_en` is high.
- R6: The status is 00 when idle and during power-up. It becomes 11 on the edge where `drive_en` rises. It stays 11 through power-down and returns to 00 on the edge where `logic_en` falls. An aborted power-up never reports 11.
- R7: If `pwr_req` drops during gap A, the block waits F frames and then drops `logic_en`, without ever enabling the display. If `pwr_req` drops during gap B, the block waits E frames, drops `disp_en`, waits F frames, and then drops `logic_en`. `drive_en` never rises in either case.
- R8: Once power-down has begun, a high `pwr_req` is ignored until `logic_en` has fallen. If `pwr_req` is still high then, a new power-up begins on the next edge.
- R9: A write in idle applies at once, including a write in the same cycle that `pwr_req` is first seen. A write during any sequence leaves that sequence's gaps unchanged and applies at the next power-up. The last write wins.
- R10: Gap counting advances only on `frame_tick`. Ticks in idle have no effect. When `pwr_req` drops in the same cycle as the tick that would end a power-up gap, the drop takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse at each frame start |
| pwr_req | input | 1 | Level: panel power wanted |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word to write |
| logic_en | output | 1 | Logic supply enable |
| disp_en | output | 1 | Display data and timing output enable |
| drive_en | output | 1 | Drive-voltage supply enable |
| pwr_status | output | 2 | 00 panel off, 11 panel on |

## Verification
Two pairs of events can land in the same cycle. The first pair is a configuration write and the first high sample of the request. The bench drives both together and checks that the very next gap follows the newly written field. The second pair is a request drop and the frame tick that would end a power-up gap. The bench drives that coincidence both directed and under random stimulus. A cycle-level bench model judges it, expecting the drop to win, so the next enable never rises.

// File: rtl/lcd_pwr_pkg.sv
package lcd_pwr_pkg;
  typedef enum logic [2:0] {
    PS_OFF    = 3'd0,
    PS_GAP_A  = 3'd1,
    PS_GAP_B  = 3'd2,
    PS_FULL   = 3'd3,
    PS_GAP_E  = 3'd4,
    PS_GAP_F  = 3'd5
  } pstate_e;

  localparam int unsigned NUM_GAPS = 4;
  localparam int unsigned IDX_A = 3;
  localparam int unsigned IDX_B = 2;
  localparam int unsigned IDX_E = 1;
  localparam int unsigned IDX_F = 0;
endpackage

// File: rtl/lcd_pwr_cfg.sv
module lcd_pwr_cfg #(
  parameter int unsigned GAP_W = 4,
  parameter int unsigned NG = 4,
  parameter logic [NG*GAP_W-1:0] RST_VAL = 16'hF60F
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       idle,
  input  logic                       we,
  input  logic [NG*GAP_W-1:0]        wdata,
  output logic [NG-1:0][GAP_W-1:0]   gaps
);
  localparam int unsigned CW = NG * GAP_W;

  logic [CW-1:0] shadow_q;
  logic [CW-1:0] act_q;
  logic [CW-1:0] eff;

  // a write in idle is visible the same cycle it arrives
  assign eff = we ? wdata : shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= RST_VAL;
      act_q    <= RST_VAL;
    end else begin
      if (we)   shadow_q <= wdata;
      if (idle) act_q    <= eff;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NG; gi++) begin : g_slice
      assign gaps[gi] = idle ? eff[gi*GAP_W +: GAP_W] : act_q[gi*GAP_W +: GAP_W];
    end
  endgenerate

  // R9: a running sequence never sees its gaps change
  p_hold_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && $past(!idle)) |-> $stable(act_q));
endmodule

// File: rtl/lcd_pwr_gap_cnt.sv
module lcd_pwr_gap_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  assign expired = tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q));
  p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/lcd_pwr_fsm.sv
module lcd_pwr_fsm
  import lcd_pwr_pkg::*;
#(
  parameter int unsigned GAP_W = 4,
  parameter int unsigned STAT_W = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req,
  input  logic                           expired,
  input  logic [NUM_GAPS-1:0][GAP_W-1:0] gaps,
  output logic                           idle,
  output logic                           load,
  output logic [GAP_W-1:0]               load_val,
  output logic                           logic_en,
  output logic                           disp_en,
  output logic                           drive_en,
  output logic [STAT_W-1:0]              status
);
  pstate_e st_q, nxt;
  logic    on_q;

  always_comb begin
    nxt      = st_q;
    load     = 1'b0;
    load_val = '0;
    unique case (st_q)
      PS_OFF: if (req) begin
        nxt = PS_GAP_A; load = 1'b1; load_val = gaps[IDX_A];
      end
      PS_GAP_A: if (!req) begin
        nxt = PS_GAP_F; load = 1'b1; load_val = gaps[IDX_F];
      end else if (expired) begin
        nxt = PS_GAP_B; load = 1'b1; load_val = gaps[IDX_B];
      end
      PS_GAP_B: if (!req) begin
        nxt = PS_GAP_E; load = 1'b1; load_val = gaps[IDX_E];
      end else if (expired) begin
        nxt = PS_FULL;
      end
      PS_FULL: if (!req) begin
        nxt = PS_GAP_E; load = 1'b1; load_val = gaps[IDX_E];
      end
      PS_GAP_E: if (expired) begin
        nxt = PS_GAP_F; load = 1'b1; load_val = gaps[IDX_F];
      end
      PS_GAP_F: if (expired) nxt = PS_OFF;
      default: nxt = PS_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= PS_OFF;
      on_q <= 1'b0;
    end else begin
      st_q <= nxt;
      if (nxt == PS_FULL)     on_q <= 1'b1;
      else if (nxt == PS_OFF) on_q <= 1'b0;
    end
  end

  assign idle     = (st_q == PS_OFF);
  assign logic_en = (st_q != PS_OFF);
  assign disp_en  = (st_q == PS_GAP_B) || (st_q == PS_FULL) || (st_q == PS_GAP_E);
  assign drive_en = (st_q == PS_FULL);
  assign status   = {STAT_W{on_q}};

  p_disp_needs_logic_r5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> logic_en);
  p_drive_needs_disp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> disp_en);
  p_disp_after_logic_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_en) |-> $past(logic_en));
  p_drive_after_disp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> $past(disp_en));
  p_logic_off_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(logic_en) |-> !$past(disp_en));
  p_disp_off_after_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disp_en) |-> !$past(drive_en));
  p_status_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> drive_en);
  p_status_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> !logic_en);
  p_status_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] == status[STAT_W-1]);
  p_gap_a_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_GAP_B && $past(st_q) == PS_GAP_A) |-> $past(expired));
  p_off_completes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == PS_GAP_F && st_q != PS_GAP_F) |-> st_q == PS_OFF);
  p_abort_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == PS_GAP_A && !$past(req)) |-> !disp_en);
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
  import lcd_pwr_pkg::*;
#(
  parameter int unsigned GAP_W = 4,
  parameter int unsigned STAT_W = 2,
  parameter logic [NUM_GAPS*GAP_W-1:0] RST_CFG = 16'hF60F
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_tick,
  input  logic                       pwr_req,
  input  logic                       cfg_we,
  input  logic [NUM_GAPS*GAP_W-1:0]  cfg_wdata,
  output logic                       logic_en,
  output logic                       disp_en,
  output logic                       drive_en,
  output logic [STAT_W-1:0]          pwr_status
);
  logic                           idle;
  logic                           load;
  logic                           expired;
  logic [GAP_W-1:0]               load_val;
  logic [NUM_GAPS-1:0][GAP_W-1:0] gaps;

  lcd_pwr_cfg #(.GAP_W(GAP_W), .NG(NUM_GAPS), .RST_VAL(RST_CFG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .idle(idle), .we(cfg_we),
    .wdata(cfg_wdata), .gaps(gaps)
  );

  lcd_pwr_gap_cnt #(.W(GAP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick), .load(load),
    .load_val(load_val), .expired(expired)
  );

  lcd_pwr_fsm #(.GAP_W(GAP_W), .STAT_W(STAT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(pwr_req), .expired(expired),
    .gaps(gaps), .idle(idle), .load(load), .load_val(load_val),
    .logic_en(logic_en), .disp_en(disp_en), .drive_en(drive_en),
    .status(pwr_status)
  );
endmodule

// File: tb/tb_lcd_pwr_seq.sv
`timescale 1ns/1ps
module tb_lcd_pwr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_tick = 1'b0;
  logic        pwr_req = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        logic_en, disp_en, drive_en;
  logic [1:0]  pwr_status;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lcd_pwr_seq dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .pwr_req(pwr_req),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .logic_en(logic_en),
    .disp_en(disp_en), .drive_en(drive_en), .pwr_status(pwr_status)
  );

  // bench model: phase 0 idle, 1 gap A, 2 gap B, 3 full, 4 gap E, 5 gap F
  int          m_ph = 0;
  int          m_cnt = 0;
  logic [15:0] m_sh = 16'hF60F;
  logic [15:0] m_act = 16'hF60F;
  bit          m_on = 0;
  bit          seen_disp, seen_drive, seen_on;

  function automatic int fld(logic [15:0] w, int idx);
    return int'(w[idx*4 +: 4]);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(bit rq, bit tk, bit we, logic [15:0] wd);
    logic [15:0] eff, cur;
    int nph, lv;
    bit ld, fin;
    eff = we ? wd : m_sh;
    cur = (m_ph == 0) ? eff : m_act;
    fin = tk && (m_cnt == 0);
    nph = m_ph; ld = 0; lv = 0;
    case (m_ph)
      0: if (rq) begin nph = 1; ld = 1; lv = fld(cur, 3); end
      1: if (!rq) begin nph = 5; ld = 1; lv = fld(cur, 0); end
         else if (fin) begin nph = 2; ld = 1; lv = fld(cur, 2); end
      2: if (!rq) begin nph = 4; ld = 1; lv = fld(cur, 1); end
         else if (fin) nph = 3;
      3: if (!rq) begin nph = 4; ld = 1; lv = fld(cur, 1); end
      4: if (fin) begin nph = 5; ld = 1; lv = fld(cur, 0); end
      5: if (fin) nph = 0;
      default: nph = 0;
    endcase
    if (m_ph == 0) m_act = eff;
    if (we) m_sh = wd;
    if (ld) m_cnt = lv;
    else if (tk && m_cnt != 0) m_cnt--;
    if (nph == 3) m_on = 1;
    else if (nph == 0) m_on = 0;
    m_ph = nph;
  endtask

  task automatic step(bit rq, bit tk, bit we = 0, logic [15:0] wd = '0);
    pwr_req = rq; frame_tick = tk; cfg_we = we; cfg_wdata = wd;
    @(posedge clk);
    model_step(rq, tk, we, wd);
    #1;
    // R5: enables follow the bench model and keep their nesting
    chk(logic_en == (m_ph != 0), "R5 logic_en vs model", logic_en, m_ph != 0);
    chk(disp_en == (m_ph inside {2, 3, 4}), "R5 disp_en vs model", disp_en, m_ph inside {2, 3, 4});
    chk(drive_en == (m_ph == 3), "R5 drive_en vs model", drive_en, m_ph == 3);
    chk(pwr_status == {2{m_on}}, "R6 status vs model", pwr_status, {2{m_on}});
    if (disp_en) seen_disp = 1;
    if (drive_en) seen_drive = 1;
    if (pwr_status != 0) seen_on = 1;
    @(negedge clk);
  endtask

  function automatic bit outsel(int s);
    return (s == 0) ? logic_en : (s == 1) ? disp_en : drive_en;
  endfunction

  // run with a tick every second cycle until output s changes; count ticks
  task automatic measure(int s, bit rq, output int n);
    bit start;
    start = outsel(s);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      bit tk;
      tk = (i % 2 == 1);
      step(rq, tk);
      if (tk) n++;
      if (outsel(s) != start) break;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(logic_en == 0 && disp_en == 0 && drive_en == 0, "R1 enables after reset",
        {logic_en, disp_en, drive_en}, 0);
    chk(pwr_status == 2'b00, "R1 status after reset", pwr_status, 0);
    @(negedge clk);

    // default gaps, power up
    step(1, 0);
    chk(logic_en && !disp_en, "R2 logic first", {logic_en, disp_en}, 2);
    measure(1, 1, n); chk(n == 16, "R1 default gap A", n, 16);
    chk(!drive_en && pwr_status == 0, "R6 status low before drive", pwr_status, 0);
    measure(2, 1, n); chk(n == 7, "R1 default gap B", n, 7);
    chk(pwr_status == 2'b11, "R6 status on with drive", pwr_status, 3);

    // write while full: held for next sequence
    step(1, 0, 1, 16'h1230);
    step(0, 0);
    chk(!drive_en && disp_en, "R4 drive off first", {drive_en, disp_en}, 1);
    measure(1, 0, n); chk(n == 1, "R9 held write keeps default E", n, 1);
    chk(pwr_status == 2'b11, "R6 status held in power-down", pwr_status, 3);
    measure(0, 0, n); chk(n == 16, "R4 default gap F", n, 16);
    chk(pwr_status == 2'b00, "R6 status off with logic", pwr_status, 0);

    // ticks in idle do nothing
    for (int i = 0; i < 6; i++) step(0, 1);
    chk(!logic_en && pwr_status == 0, "R10 idle ticks ignored", logic_en, 0);

    // new fields 0x1230
    step(1, 0);
    measure(1, 1, n); chk(n == 2, "R3 field A=1", n, 2);
    measure(2, 1, n); chk(n == 3, "R3 field B=2", n, 3);
    step(0, 0);
    measure(1, 0, n); chk(n == 4, "R3 field E=3", n, 4);
    measure(0, 0, n); chk(n == 1, "R3 field F=0", n, 1);

    // write in the same cycle as the request
    step(1, 0, 1, 16'h0000);
    measure(1, 1, n); chk(n == 1, "R9 same-cycle write applies", n, 1);
    step(0, 0);
    measure(0, 0, n);

    // abort during gap A, drop together with the ending tick
    step(0, 0, 1, 16'h1005);
    seen_disp = 0; seen_drive = 0; seen_on = 0;
    step(1, 0);
    step(1, 1);
    step(0, 1);
    chk(logic_en && !disp_en, "R10 drop beats tick in gap A", disp_en, 0);
    measure(0, 0, n); chk(n == 6, "R7 abort in A waits F", n, 6);
    chk(!seen_disp && !seen_drive && !seen_on, "R7 abort in A no display",
        {seen_disp, seen_drive, seen_on}, 0);

    // abort during gap B
    step(0, 0, 1, 16'h0510);
    seen_drive = 0; seen_on = 0;
    step(1, 0);
    measure(1, 1, n);
    step(1, 1); step(1, 0);
    step(0, 1);
    measure(1, 0, n); chk(n == 2, "R7 abort in B waits E", n, 2);
    measure(0, 0, n); chk(n == 1, "R7 abort in B then F", n, 1);
    chk(!seen_drive && !seen_on, "R6 aborted power-up never reports on",
        {seen_drive, seen_on}, 0);

    // request back during power-down
    step(0, 0, 1, 16'h0033);
    step(1, 0);
    measure(2, 1, n);
    step(0, 0);
    measure(1, 1, n); chk(n == 4, "R8 re-request ignored in E", n, 4);
    measure(0, 1, n); chk(n == 4, "R8 re-request ignored in F", n, 4);
    step(1, 0);
    chk(logic_en == 1, "R8 restart after off", logic_en, 1);
    step(0, 0);
    measure(0, 0, n);
    measure(0, 0, n);

    // random phase
    begin
      int unsigned seed;
      bit rq;
      seed = $urandom(32'h5eed);
      rq = 0;
      for (int i = 0; i < 4000; i++) begin
        bit tk, we;
        if ($urandom_range(0, 29) == 0) rq = ~rq;
        tk = ($urandom_range(0, 2) == 0);
        we = ($urandom_range(0, 24) == 0);
        step(rq, tk, we, 16'($urandom) & 16'h3333);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule